// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Converter

This block sits in an always-on domain between a bank of wakeup interrupt pins and a downstream interrupt controller that only understands active-high levels and rising edges. Each pin carries a 3-bit sense code of the form {polarity, falling, rising}. The block brings every pin through a two-flop synchronizer and then reshapes it. Level inputs leave as active-high levels. Edge inputs leave as one-clock rising pulses. Active-low and falling-edge sources are inverted, and a dual-edge mode turns either transition into a pulse.

Software programs the block through a small register port. Per-pin enable bits are packed into 32-bit words starting at 0x10: pin n is bit n%32 of the word at 0x10 + 4*(n/32). Each pin also has its own configuration word at 0x110 + 4*n. A disabled pin holds its output low, and any edge it sees while disabled is lost.

Top module: `wake_irq_conditioner`

## Requirements
- R1: After synchronous reset every enable bit is 0, every configuration code is 3'b100 and every output is 0.
- R2: Writing the word at 0x10 + 4*k sets the enable of pin 32*k+b from data bit b. Reading it returns those enables. Bit positions with no pin read as 0.
- R3: Configuration for pin n is at 0x110 + 4*n. Writes keep data bits [2:0] as {polarity, falling, rising}. Reads return the code with bits [31:3] at 0. Unaligned and unmapped addresses read 0 and writes to them change nothing.
- R4: Code 3'b100 passes the input through as an active-high level. An input value sampled at rising edge t appears on the output after edge t+2.
- R5: Code 3'b000 outputs the inverse of the input as an active-high level, with the same latency as R4.
- R6: Code 3'b010 emits a one-clock high pulse for each high-to-low input transition.
- R7: Code 3'b110 emits a one-clock high pulse for each low-to-high input transition.
- R8: Code 3'b111 emits a one-clock high pulse for each input transition in either direction.
- R9: The unused codes 3'b001, 3'b011 and 3'b101 behave exactly as 3'b100.
- R10: While a pin's enable is 0 its output is 0. An edge that occurs while the pin is disabled produces no pulse after the pin is enabled again.
- R11: Read data appears on the read-data port the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Raw asynchronous wakeup interrupt pins |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_PINS | Conditioned active-high interrupt lines, one per pin |

## Verification
A corrupted synchronizer or previous-sample flop shows up at the output as a pulse one cycle early or late, as a missing pulse, or as a second pulse. The per-cycle comparison of every output line catches this within three clock edges of the input change. A wrong configuration or enable bit changes an output's polarity or gating on the next sampled input. The same bit also reads back wrong at its own address on the cycle after the read strobe. The register checks include the partial last enable word and the unaligned and unmapped holes. These show a decode that reaches the wrong pin or leaks stale bits.

// File: rtl/wic_pkg.sv
package wic_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 3;

    // Default register layout (byte addresses)
    localparam int DEF_EN_BASE  = 'h010;
    localparam int DEF_CFG_BASE = 'h110;

    // Sense code reset value: level, active high
    localparam logic [CODE_W-1:0] CODE_RESET = 3'b100;

    typedef enum logic [2:0] {
        KIND_LVL_HIGH,
        KIND_LVL_LOW,
        KIND_RISE,
        KIND_FALL,
        KIND_BOTH
    } sense_kind_e;

    // Synchronizer and history for one pin
    typedef struct packed {
        logic meta;    // first capture flop
        logic stable;  // second capture flop, safe to use
        logic last;    // stable value one cycle older
    } pin_sync_t;

    // Code layout is {polarity, falling, rising}
    function automatic sense_kind_e decode_code(input logic [CODE_W-1:0] code);
        sense_kind_e k;
        case (code)
            3'b000:  k = KIND_LVL_LOW;
            3'b010:  k = KIND_FALL;
            3'b110:  k = KIND_RISE;
            3'b111:  k = KIND_BOTH;
            default: k = KIND_LVL_HIGH;  // 100 and the unused codes
        endcase
        return k;
    endfunction

    function automatic logic sense_hit(input sense_kind_e k, input pin_sync_t s);
        logic h;
        case (k)
            KIND_LVL_LOW: h = ~s.stable;
            KIND_RISE:    h = s.stable & ~s.last;
            KIND_FALL:    h = ~s.stable & s.last;
            KIND_BOTH:    h = s.stable ^ s.last;
            default:      h = s.stable;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/wic_pin_cond.sv
module wic_pin_cond
    import wic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    output logic              irq_o
);

    pin_sync_t   st_q;
    sense_kind_e kind;
    logic        hit;

    assign kind = decode_code(code);
    assign hit  = sense_hit(kind, st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            irq_o <= 1'b0;
        end else begin
            st_q.meta   <= pin_in;
            st_q.stable <= st_q.meta;
            st_q.last   <= st_q.stable;
            irq_o       <= enable & hit;
        end
    end

    // R10
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !irq_o);

    // R7
    rise_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && kind == KIND_RISE && $stable(kind)) |=> (kind != KIND_RISE || !irq_o));

    // R6
    fall_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && kind == KIND_FALL && $stable(kind)) |=> (kind != KIND_FALL || !irq_o));

endmodule

// File: rtl/wic_reg_file.sv
module wic_reg_file
    import wic_pkg::*;
#(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12,
    parameter int EN_BASE  = DEF_EN_BASE,
    parameter int CFG_BASE = DEF_CFG_BASE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [WORD_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [WORD_W-1:0]          bus_rdata,
    output logic [NUM_PINS-1:0]        en_bits,
    output logic [CODE_W*NUM_PINS-1:0] cfg_flat
);

    localparam int EN_WORDS  = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int EW_W      = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int TAIL_BITS = NUM_PINS - WORD_W * (EN_WORDS - 1);

    logic [ADDR_W-1:0] en_off, cfg_off;
    logic              aligned, en_hit, cfg_hit;
    logic [EW_W-1:0]   en_word;
    logic [PIN_W-1:0]  cfg_sel;
    logic [WORD_W-1:0] rd_val;
    logic [CODE_W-1:0] cfg_q [NUM_PINS];

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign en_off  = bus_addr - ADDR_W'(EN_BASE);
    assign cfg_off = bus_addr - ADDR_W'(CFG_BASE);
    assign en_hit  = aligned && ((en_off >> 2) < ADDR_W'(EN_WORDS));
    assign cfg_hit = aligned && ((cfg_off >> 2) < ADDR_W'(NUM_PINS));
    assign en_word = EW_W'(en_off >> 2);
    assign cfg_sel = PIN_W'(cfg_off >> 2);

    always_comb begin
        rd_val = '0;
        if (en_hit) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if ((i / WORD_W) == int'(en_word)) rd_val[i % WORD_W] = en_bits[i];
            end
        end
        if (cfg_hit) rd_val[CODE_W-1:0] = cfg_q[cfg_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_bits   <= '0;
            bus_rdata <= '0;
            for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= CODE_RESET;
        end else begin
            if (bus_wr && en_hit) begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if ((i / WORD_W) == int'(en_word)) en_bits[i] <= bus_wdata[i % WORD_W];
                end
            end
            if (bus_wr && cfg_hit) cfg_q[cfg_sel] <= bus_wdata[CODE_W-1:0];
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
        assign cfg_flat[CODE_W*g +: CODE_W] = cfg_q[g];
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (en_bits == '0 && bus_rdata == '0));

    // R3
    cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && cfg_hit) |=> (bus_rdata[WORD_W-1:CODE_W] == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    if (TAIL_BITS < WORD_W) begin : g_tail
        // R2
        en_tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && en_hit && int'(en_word) == EN_WORDS - 1)
            |=> ((bus_rdata >> TAIL_BITS) == '0));
    end

endmodule

// File: rtl/wake_irq_conditioner.sv
module wake_irq_conditioner
    import wic_pkg::*;
#(
    parameter int NUM_PINS = 126,
    parameter int ADDR_W   = 12,
    parameter int EN_BASE  = DEF_EN_BASE,
    parameter int CFG_BASE = DEF_CFG_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_out
);

    logic [NUM_PINS-1:0]        en_bits;
    logic [CODE_W*NUM_PINS-1:0] cfg_flat;

    wic_reg_file #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .EN_BASE  (EN_BASE),
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .en_bits   (en_bits),
        .cfg_flat  (cfg_flat)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wic_pin_cond u_pin (
            .clk    (clk),
            .rst    (rst),
            .pin_in (irq_in[g]),
            .enable (en_bits[g]),
            .code   (cfg_flat[CODE_W*g +: CODE_W]),
            .irq_o  (irq_out[g])
        );
    end

endmodule

// File: tb/wake_irq_conditioner_tb_top.sv
module wake_irq_conditioner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP   = 126;
    localparam int AW   = 12;
    localparam int EN_B = 'h010;
    localparam int CF_B = 'h110;
    localparam int NW   = (NP + 31) / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] irq_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, built from the requirements
    bit       me [NP];
    bit [2:0] mc [NP];
    bit       m1 [NP], m2 [NP], mp [NP], mo [NP];

    wake_irq_conditioner #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit sense(input bit [2:0] c, input bit cur, input bit prv);
        case (c)
            3'b000:  return !cur;          // R5
            3'b010:  return !cur && prv;   // R6
            3'b110:  return cur && !prv;   // R7
            3'b111:  return cur != prv;    // R8
            default: return cur;           // R4, R9
        endcase
    endfunction

    function automatic string tag_of(input int p);
        if (!me[p]) return "R10";
        case (mc[p])
            3'b000:  return "R5";
            3'b100:  return "R4";
            3'b010:  return "R6";
            3'b110:  return "R7";
            3'b111:  return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic bit [31:0] exp_read(input int a);
        bit [31:0] v = '0;
        if (a % 4 != 0) return v;
        if (a >= EN_B && a < EN_B + 4*NW) begin
            for (int b = 0; b < 32; b++) begin
                if (32*((a - EN_B)/4) + b < NP) v[b] = me[32*((a - EN_B)/4) + b];
            end
        end else if (a >= CF_B && a < CF_B + 4*NP) begin
            v[2:0] = mc[(a - CF_B)/4];
        end
        return v;
    endfunction

    // Reference model: outputs use the old register state, then writes land
    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                me[p] = 1'b0; mc[p] = 3'b100;
                m1[p] = 1'b0; m2[p] = 1'b0; mp[p] = 1'b0; mo[p] = 1'b0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                mo[p] = me[p] && sense(mc[p], m2[p], mp[p]);
                mp[p] = m2[p];
                m2[p] = m1[p];
                m1[p] = irq_in[p];
            end
            if (bus_wr && bus_addr[1:0] == 2'b00) begin
                if (int'(bus_addr) >= EN_B && int'(bus_addr) < EN_B + 4*NW) begin
                    for (int b = 0; b < 32; b++) begin
                        if (32*((int'(bus_addr) - EN_B)/4) + b < NP)
                            me[32*((int'(bus_addr) - EN_B)/4) + b] = bus_wdata[b];
                    end
                end else if (int'(bus_addr) >= CF_B && int'(bus_addr) < CF_B + 4*NP) begin
                    mc[(int'(bus_addr) - CF_B)/4] = bus_wdata[2:0];
                end
            end
        end
    end

    // Continuous per-cycle comparison of every line (R4..R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            for (int p = 0; p < NP; p++) begin
                if (irq_out[p] !== mo[p]) begin
                    fails++;
                    $display("FAIL %s pin %0d irq_out=%0b expected=%0b t=%0t",
                             tag_of(p), p, irq_out[p], mo[p], $time);
                end
            end
        end
    end

    task automatic bus_write(input int a, input bit [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_check(input int a, input string tag);
        bit [31:0] e;
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read 0x%0h actual=0x%08h expected=0x%08h", tag, a, bus_rdata, e);
        end
        // R11: data holds while no read strobe
        @(negedge clk);
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL R11 hold 0x%0h actual=0x%08h expected=0x%08h", a, bus_rdata, e);
        end
    endtask

    task automatic set_pin(input int p, input bit v);
        @(negedge clk);
        irq_in[p] = v;
    endtask

    task automatic count_high(input int p, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_out[p]) cnt++;
        end
    endtask

    task automatic expect_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        int cnt;
        bit [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        // R1: outputs low during and right after reset
        expect_int("R1 outputs in reset", int'(irq_out != '0), 0);
        rst = 1'b0;
        @(negedge clk);
        expect_int("R1 outputs after reset", int'(irq_out != '0), 0);
        for (int k = 0; k < NW; k++) bus_check(EN_B + 4*k, "R1");
        bus_check(CF_B, "R1");
        bus_check(CF_B + 4*(NP-1), "R1");
        // R3: holes read zero
        bus_check('h000, "R3");
        bus_check(CF_B + 2, "R3");
        bus_check(CF_B + 4*NP, "R3");
        bus_write(CF_B + 1, 32'h7);
        bus_check(CF_B, "R3");
        // R2: tail bits of the last enable word
        bus_write(EN_B + 4*(NW-1), 32'hFFFF_FFFF);
        bus_check(EN_B + 4*(NW-1), "R2");
        expect_int("R2 tail", int'(bus_rdata), int'(32'h3FFF_FFFF));
        // Configure pins
        bus_write(CF_B + 4*0,   32'hFFFF_FFF6);   // 110 rising, upper bits dropped
        bus_write(CF_B + 4*37,  32'h2);           // falling
        bus_write(CF_B + 4*64,  32'h7);           // dual
        bus_write(CF_B + 4*100, 32'h0);           // level low
        bus_write(CF_B + 4*125, 32'h5);           // unused -> level high
        bus_write(CF_B + 4*3,   32'h6);           // rising, kept disabled
        bus_check(CF_B, "R3");
        bus_write(EN_B + 0, 32'h1);
        bus_write(EN_B + 4, 32'h20);
        bus_write(EN_B + 8, 32'h1);
        bus_write(EN_B + 12, (32'h1 << 4) | (32'h1 << 29));
        bus_check(EN_B + 4, "R2");
        bus_check(EN_B + 12, "R2");
        // R7: single pulse per rising edge
        set_pin(0, 1'b1);
        count_high(0, 6, cnt);
        expect_int("R7 pulse count", cnt, 1);
        set_pin(0, 1'b0);
        count_high(0, 6, cnt);
        expect_int("R7 no pulse on fall", cnt, 0);
        // R6
        set_pin(37, 1'b1);
        count_high(37, 6, cnt);
        expect_int("R6 no pulse on rise", cnt, 0);
        set_pin(37, 1'b0);
        count_high(37, 6, cnt);
        expect_int("R6 pulse count", cnt, 1);
        // R8
        set_pin(64, 1'b1);
        count_high(64, 6, cnt);
        expect_int("R8 rise pulse", cnt, 1);
        set_pin(64, 1'b0);
        count_high(64, 6, cnt);
        expect_int("R8 fall pulse", cnt, 1);
        // R5 and R4 latency: input change shows on the 3rd edge
        expect_int("R5 idle high", int'(irq_out[100]), 1);
        set_pin(100, 1'b1);
        @(negedge clk); @(negedge clk);
        expect_int("R5 not yet", int'(irq_out[100]), 1);
        @(negedge clk);
        expect_int("R5 inverted", int'(irq_out[100]), 0);
        set_pin(125, 1'b1);
        count_high(125, 5, cnt);
        expect_int("R9 level high", cnt, 3);
        // R10: edge while disabled is dropped
        set_pin(3, 1'b1);
        repeat (6) @(negedge clk);
        bus_write(EN_B + 0, 32'h9);
        count_high(3, 8, cnt);
        expect_int("R10 dropped edge", cnt, 0);
        // Random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            for (int p = 0; p < NP; p++) if ($urandom % 12 == 0) irq_in[p] = ~irq_in[p];
            case ($urandom % 16)
                0: begin
                    bus_addr = AW'(CF_B + 4*($urandom % NP)); bus_wdata = $urandom; bus_wr = 1'b1;
                end
                1: begin
                    bus_addr = AW'(EN_B + 4*($urandom % NW)); bus_wdata = $urandom; bus_wr = 1'b1;
                end
                default: ;
            endcase
            if (cyc % 200 == 199) begin
                @(negedge clk);
                bus_wr = 1'b0;
                bus_check(((cyc/200) % 2 == 0) ? EN_B + 4*($urandom % NW)
                                               : CF_B + 4*($urandom % NP), "R2/R3 random");
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule